// File: doc/BRIEF.md
# I2C control register slave

This block is a write-only I2C target that configures a display signal processor. SCL and SDA are oversampled by the system clock. START and STOP are decoded from the sampled lines. After an address byte of 88h (7-bit address 44h with the write bit clear), the block takes a subaddress byte and then one or more data bytes. The data bytes land in a bank of 24 eight-bit control registers, and every register is exported in parallel on one flat bus.

The top bit of the subaddress byte selects one of two modes:
- **Single-update mode (bit 7 = 1):** only the first data byte is stored.
- **Streaming mode (bit 7 = 0):** each data byte goes to the next register until STOP.

Writes to the two codes that would put the downstream circuit into test mode are refused. Each write that is accepted raises a one-cycle strobe together with its register index and value, so neighbouring logic can react to individual updates.

Top module: `ctl_i2c_regbank`

## Requirements
- R1: After reset, register 05h holds 40h, 0Ah holds C0h, 11h holds 03h, 12h holds 00h and 16h holds 7Fh. Every other register in 01h..18h holds 80h. Register n appears on `regs_o[8n-1 : 8n-8]`.
- R2: An address byte of 88h is acknowledged. Any other address byte, including the read form 89h, gets no acknowledge. All bytes after it get no acknowledge and cause no write until the next START.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After STOP, bytes clocked without a fresh START are neither acknowledged nor written. A repeated START without a STOP begins a new transfer.
- R4: A byte is eight bits, MSB first, sampled on SCL rising. On the ninth clock the slave pulls SDA low (`sda_oe_o` = 1) for an accepted byte. It changes `sda_oe_o` only while SCL is low.
- R5: In single-update mode (subaddress bit 7 = 1), the first data byte is written to the register given by subaddress bits 6:0. Later data bytes are acknowledged but not written.
- R6: In streaming mode (subaddress bit 7 = 0), data bytes are written to consecutive registers, starting at subaddress bits 6:0, until STOP.
- R7: Writes aimed at subaddress 00h or at anything above 18h are acknowledged and dropped. No register changes and no strobe is raised.
- R8: A write of 00h or 01h to register 17h is discarded. Any other value is stored there.
- R9: Each stored byte raises `wr_stb_o` for exactly one cycle. In that cycle, `wr_idx_o` and `wr_data_o` carry the register index and value, and `regs_o` already shows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, many times faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| sda_oe_o | output | 1 | 1 = pull SDA low (acknowledge) |
| regs_o | output | 192 | All 24 registers, register n in bits 8n-1..8n-8 |
| wr_stb_o | output | 1 | One-cycle pulse per stored byte |
| wr_idx_o | output | 5 | Register index of the stored byte |
| wr_data_o | output | 8 | Value of the stored byte |

## Verification
The assertions rely on the bus master obeying the protocol:
- SDA changes only while SCL is low, except to form a START or a STOP.
- No START or STOP occurs during an acknowledge clock, so the slave's hold on SDA never overlaps a line condition.
- Every SCL level lasts longer than the three-stage sampling delay.

The bench master keeps a quarter bit period of ten system clocks, and it releases SDA for every ninth clock. Its sweeps cover every register in both modes, the boundaries of the subaddress range, the protected codes, and rejected addresses.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
  localparam int PTR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_SKIP
  } bus_st_e;

  function automatic logic [7:0] reset_val(input int idx);
    case (idx)
      5:       return 8'h40;
      10:      return 8'hC0;
      17:      return 8'h03;
      18:      return 8'h00;
      22:      return 8'h7F;
      default: return 8'h80;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_m, scl_s, scl_q;
  logic sda_m, sda_s, sda_q;

  // bus idles high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_q <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_q <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_q <= sda_s;
    end
  end

  assign scl_o      = scl_q;
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import ctl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_oe_o,
  output logic             wr_req_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [7:0]       wr_data_o
);
  bus_st_e          st_q;
  logic [7:0]       sh_q;
  logic [3:0]       cnt_q;
  logic             ack_ph_q, oe_q, upd_q, first_q;
  logic [PTR_W-1:0] ptr_q;
  logic             wr_req_q;
  logic [PTR_W-1:0] wr_ptr_q;
  logic [7:0]       wr_data_q;
  logic             active;

  assign active = (st_q != ST_IDLE) && (st_q != ST_SKIP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      ack_ph_q  <= 1'b0;
      oe_q      <= 1'b0;
      upd_q     <= 1'b0;
      first_q   <= 1'b0;
      ptr_q     <= '0;
      wr_req_q  <= 1'b0;
      wr_ptr_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_req_q <= 1'b0;
      if (start_i) begin
        st_q <= ST_ADDR; cnt_q <= '0; ack_ph_q <= 1'b0; oe_q <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE; cnt_q <= '0; ack_ph_q <= 1'b0; oe_q <= 1'b0;
      end else if (active) begin
        if (scl_rise_i && !ack_ph_q) begin
          sh_q  <= {sh_q[6:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall_i && ack_ph_q) begin
          ack_ph_q <= 1'b0;
          oe_q     <= 1'b0;
        end else if (scl_fall_i && cnt_q == 4'd8) begin
          cnt_q <= '0;
          case (st_q)
            ST_ADDR: begin
              if (sh_q == {DEV_ADDR, 1'b0}) begin
                ack_ph_q <= 1'b1; oe_q <= 1'b1; st_q <= ST_SUB;
              end else begin
                st_q <= ST_SKIP;
              end
            end
            ST_SUB: begin
              ack_ph_q <= 1'b1; oe_q <= 1'b1;
              upd_q    <= sh_q[7];
              ptr_q    <= sh_q[PTR_W-1:0];
              first_q  <= 1'b1;
              st_q     <= ST_DATA;
            end
            ST_DATA: begin
              ack_ph_q <= 1'b1; oe_q <= 1'b1;
              first_q  <= 1'b0;
              if (!upd_q || first_q) begin
                wr_req_q  <= 1'b1;
                wr_ptr_q  <= ptr_q;
                wr_data_q <= sh_q;
              end
              // saturate so a long stream never wraps back into range
              if (!upd_q && ptr_q != {PTR_W{1'b1}})
                ptr_q <= ptr_q + {{(PTR_W-1){1'b0}}, 1'b1};
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_req_o  = wr_req_q;
  assign wr_ptr_o  = wr_ptr_q;
  assign wr_data_o = wr_data_q;

  assert_no_ack_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (st_q == ST_SUB || st_q == ST_DATA));

  assert_ack_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_i |-> $stable(oe_q));

  assert_req_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_q |=> !wr_req_q);
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_i2c_pkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int PROT_SUB = 23,
  localparam int IDX_W   = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_req_i,
  input  logic [PTR_W-1:0]      wr_ptr_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  wr_stb_o,
  output logic [IDX_W-1:0]      wr_idx_o,
  output logic [7:0]            wr_data_o
);
  logic             in_range, test_code, accept;
  logic             stb_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       dat_q;

  assign in_range  = (wr_ptr_i != '0) && (wr_ptr_i <= PTR_W'(NUM_REGS));
  assign test_code = (wr_ptr_i == PTR_W'(PROT_SUB)) && (wr_data_i <= 8'd1);
  assign accept    = wr_req_i && in_range && !test_code;

  for (genvar g = 1; g <= NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= reset_val(g);
      else if (accept && wr_ptr_i == PTR_W'(g))    q <= wr_data_i;
    end
    assign regs_o[(g-1)*8 +: 8] = q;

    if (g == PROT_SUB) begin : g_prot
      assert_prot_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q > 8'd1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      idx_q <= '0;
      dat_q <= '0;
    end else begin
      stb_q <= accept;
      if (accept) begin
        idx_q <= wr_ptr_i[IDX_W-1:0];
        dat_q <= wr_data_i;
      end
    end
  end

  assign wr_stb_o  = stb_q;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = dat_q;

  assert_stb_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);

  assert_stb_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> (idx_q != '0 && int'(idx_q) <= NUM_REGS));

  assert_stb_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> regs_o[int'(idx_q)*8-8 +: 8] == dat_q);
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank
  import ctl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int         NUM_REGS = 24,
  parameter int         PROT_SUB = 23,
  localparam int        IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  wr_stb_o,
  output logic [IDX_W-1:0]      wr_idx_o,
  output logic [7:0]            wr_data_o
);
  logic             scl_lvl, sda_smp, scl_rise, scl_fall, start, stop;
  logic             wr_req;
  logic [PTR_W-1:0] wr_ptr;
  logic [7:0]       wr_byte;

  i2c_line_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_lvl),
    .sda_o      (sda_smp),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_lvl),
    .sda_i      (sda_smp),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .sda_oe_o   (sda_oe_o),
    .wr_req_o   (wr_req),
    .wr_ptr_o   (wr_ptr),
    .wr_data_o  (wr_byte)
  );

  ctl_reg_bank #(.NUM_REGS(NUM_REGS), .PROT_SUB(PROT_SUB)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_req_i  (wr_req),
    .wr_ptr_i  (wr_ptr),
    .wr_data_i (wr_byte),
    .regs_o    (regs_o),
    .wr_stb_o  (wr_stb_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o)
  );
endmodule

// File: tb/ctl_i2c_regbank_tb.sv
`timescale 1ns/1ps
module ctl_i2c_regbank_tb_top;
  localparam int NR = 24;
  localparam int Q  = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          scl_m = 1'b1;
  logic          sda_m = 1'b1;
  logic          sda_oe_o;
  logic [NR*8-1:0] regs_o;
  logic          wr_stb_o;
  logic [4:0]    wr_idx_o;
  logic [7:0]    wr_data_o;
  wire           sda_line = sda_m & ~sda_oe_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_r [1:NR];
  int exp_stb = 0, stb_cnt = 0;
  int exp_idx = 0, exp_dat = 0, last_idx = 0, last_dat = 0;
  logic [7:0] dbuf [0:31];

  always #2.5 clk_i = ~clk_i;

  ctl_i2c_regbank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .regs_o(regs_o), .wr_stb_o(wr_stb_o),
    .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o)
  );

  always @(negedge clk_i) if (rst_ni && wr_stb_o) begin
    stb_cnt++;
    last_idx = int'(wr_idx_o);
    last_dat = int'(wr_data_o);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] rst_val(input int i);
    if (i == 5) return 8'h40;
    if (i == 10) return 8'hC0;
    if (i == 17) return 8'h03;
    if (i == 18) return 8'h00;
    if (i == 22) return 8'h7F;
    return 8'h80;
  endfunction

  task automatic model_wr(input int p, input logic [7:0] v);
    if (p >= 1 && p <= NR && !(p == 23 && v < 8'd2)) begin
      exp_r[p] = v;
      exp_stb++;
      exp_idx = p;
      exp_dat = int'(v);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; qwait(Q);
    scl_m = 1'b1; qwait(Q);
    sda_m = 1'b0; qwait(Q);
    scl_m = 1'b0; qwait(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; qwait(Q);
    scl_m = 1'b1; qwait(Q);
    sda_m = 1'b1; qwait(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; qwait(Q);
      scl_m = 1'b1; qwait(2*Q);
      scl_m = 1'b0; qwait(Q);
    end
    sda_m = 1'b1; qwait(Q);
    scl_m = 1'b1; qwait(Q);
    ack = ~sda_line;
    qwait(Q);
    scl_m = 1'b0; qwait(Q);
  endtask

  task automatic check_all(input string tag);
    qwait(8);
    for (int i = 1; i <= NR; i++)
      chk(regs_o[i*8-1 -: 8] == exp_r[i], tag, int'(regs_o[i*8-1 -: 8]), int'(exp_r[i]));
    chk(stb_cnt == exp_stb, {tag, " R9 strobe count"}, stb_cnt, exp_stb);
    chk(last_idx == exp_idx && last_dat == exp_dat, {tag, " R9 last strobe"},
        last_idx*256 + last_dat, exp_idx*256 + exp_dat);
  endtask

  task automatic do_write(input logic [7:0] sub, input int n, input string tag);
    bit ak;
    int p;
    i2c_start;
    send_byte(8'h88, ak); chk(ak, {tag, " R2 addr ack"}, int'(ak), 1);
    send_byte(sub, ak);   chk(ak, {tag, " R4 sub ack"}, int'(ak), 1);
    p = int'(sub[6:0]);
    for (int k = 0; k < n; k++) begin
      send_byte(dbuf[k], ak);
      chk(ak, {tag, " R4 data ack"}, int'(ak), 1);
      if (!sub[7] || k == 0) model_wr(p, dbuf[k]);
      if (!sub[7] && p != 127) p++;
    end
    i2c_stop;
    check_all(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ak;
    for (int i = 1; i <= NR; i++) exp_r[i] = rst_val(i);
    qwait(5);
    rst_ni = 1'b1;
    qwait(5);

    // R1 reset state
    check_all("R1 reset");
    chk(sda_oe_o == 1'b0, "R1 sda idle", int'(sda_oe_o), 0);

    // R6 stream across all registers
    for (int k = 0; k < NR; k++) dbuf[k] = 8'((k + 1) * 29 + 3);
    do_write(8'h01, NR, "R6 stream");

    // R5 single update per register, extra bytes dropped
    for (int i = 1; i <= NR; i++) begin
      dbuf[0] = 8'(i * 11 + 64);
      dbuf[1] = ~dbuf[0];
      dbuf[2] = 8'h5A;
      do_write(8'h80 | 8'(i), 3, "R5 update");
    end

    // R8 protected codes
    dbuf[0] = 8'h00; do_write(8'h97, 1, "R8 code00");
    dbuf[0] = 8'h01; do_write(8'h97, 1, "R8 code01");
    dbuf[0] = 8'h02; do_write(8'h97, 1, "R8 code02");
    dbuf[0] = 8'h01; dbuf[1] = 8'h66; do_write(8'h17, 2, "R8 stream");
    dbuf[0] = 8'hFF; do_write(8'h17, 1, "R8 codeFF");

    // R7 out-of-range subaddresses
    dbuf[0] = 8'hA5; dbuf[1] = 8'h5A; dbuf[2] = 8'h3C; dbuf[3] = 8'hC3;
    do_write(8'h17, 4, "R7 past end");
    dbuf[0] = 8'h11; do_write(8'h80, 1, "R7 sub00 update");
    dbuf[0] = 8'h22; dbuf[1] = 8'h33; do_write(8'h00, 2, "R7 sub00 stream");
    dbuf[0] = 8'h44; dbuf[1] = 8'h55; do_write(8'h20, 2, "R7 sub20");
    dbuf[0] = 8'h77; do_write(8'h99, 1, "R7 sub19");

    // R2 wrong addresses
    foreach (dbuf[k]) dbuf[k] = 8'h00;
    for (int a = 0; a < 6; a++) begin
      logic [7:0] ab;
      case (a)
        0: ab = 8'h89; 1: ab = 8'h8A; 2: ab = 8'h08;
        3: ab = 8'h98; 4: ab = 8'hC8; default: ab = 8'h00;
      endcase
      i2c_start;
      send_byte(ab, ak);    chk(!ak, "R2 nack addr", int'(ak), 0);
      send_byte(8'h01, ak); chk(!ak, "R2 nack sub", int'(ak), 0);
      send_byte(8'h88, ak); chk(!ak, "R2 nack data", int'(ak), 0);
      i2c_stop;
      check_all("R2 wrong addr");
    end

    // R2 skip ends at next START
    i2c_start;
    send_byte(8'h8C, ak); chk(!ak, "R2 nack before restart", int'(ak), 0);
    dbuf[0] = 8'h9D;
    do_write(8'h86, 1, "R2 restart");

    // R3 bytes after STOP without START
    send_byte(8'h88, ak); chk(!ak, "R3 no start addr", int'(ak), 0);
    send_byte(8'h02, ak); chk(!ak, "R3 no start sub", int'(ak), 0);
    send_byte(8'hE1, ak); chk(!ak, "R3 no start data", int'(ak), 0);
    check_all("R3 after stop");

    // R3 repeated START without STOP
    i2c_start;
    send_byte(8'h88, ak); chk(ak, "R3 rs addr", int'(ak), 1);
    send_byte(8'h02, ak); chk(ak, "R3 rs sub", int'(ak), 1);
    send_byte(8'h12, ak); chk(ak, "R3 rs data", int'(ak), 1);
    model_wr(2, 8'h12);
    i2c_start;
    send_byte(8'h88, ak); chk(ak, "R3 rs addr2", int'(ak), 1);
    send_byte(8'h83, ak); chk(ak, "R3 rs sub2", int'(ak), 1);
    send_byte(8'h34, ak); chk(ak, "R3 rs data2", int'(ak), 1);
    model_wr(3, 8'h34);
    i2c_stop;
    check_all("R3 repeated start");
    chk(sda_oe_o == 1'b0, "R4 sda released", int'(sda_oe_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule